// File: doc/BRIEF.md
# Activity Statistics Sniffer Counter

This block sits beside a processor and its memory ports and watches them without affecting them. It samples the processor's state code, four memory access strobes and an interconnect data bus on every clock. From these it builds statistics for an external thermal model: cycles spent active, stalled and idle, accesses per memory target, and bit toggles on the bus. A toggle is any bit whose value differs from the previous counted cycle.

Operation is split into fixed sampling intervals of `INTERVAL` counted cycles. In summary mode the accumulators are written as one record into an internal buffer at the end of each interval, and they then restart from zero. In event mode the block instead writes one record for every cycle that shows a memory access, and it writes no summary records. A dispatcher drains the buffer through a valid/read interface.

The buffer may be full when a record is produced. In that case the record is held in a pending slot and a stall request is raised, so that the monitored processor can be stopped. While the request is up, the block ignores its monitored inputs, and no record is ever lost.

Top module: `activity_sniffer`

## Requirements
- R1: Each counted cycle adds one to exactly one state counter, selected by `cpu_state`: 2'b01 counts as active, 2'b10 as stalled and 2'b00 as idle. The code 2'b11 adds to none of them.
- R2: Each counted cycle adds one to the access counter of every `mem_acc` bit that is high. The bits map as follows: bit 0 is instruction cache, bit 1 is data cache, bit 2 is private main memory and bit 3 is shared main memory.
- R3: Each counted cycle adds the population count of `bus_data` XOR the bus value of the previous counted cycle to the toggle counter. After reset the previous value is zero.
- R4: In summary mode, a record is produced on the `INTERVAL`-th counted cycle of each interval. That record includes the contribution of that cycle. The next interval starts with all accumulators at zero.
- R5: Every accumulator saturates at 2^CNT_W-1 and never wraps.
- R6: A record is nine CNT_W-wide fields, where field k sits at bits [k*CNT_W +: CNT_W]. In a summary record, field 0 is 0 and fields 1 to 8 hold active, stalled, idle, instruction cache, data cache, private memory, shared memory and toggles.
- R7: `rd_valid` is high while the buffer holds a record, and `rd_data` shows the oldest record. A cycle with `rd_en` and `rd_valid` both high removes that record. Records leave in the order they were produced.
- R8: A record produced while the buffer is full and no read is taking place is held, not dropped. `stall_req` rises on the next cycle and stays high until a read frees space, at which point the held record enters the buffer. During stalled cycles the monitored inputs are ignored, and the interval position does not advance.
- R9: A read and a new record in the same cycle with a full buffer both take effect, and `stall_req` stays low.
- R10: With `evt_mode` high, every counted cycle in which any `mem_acc` bit is set produces an event record, and no summary record is produced. An event record carries: field 0 = 1, field 1 = the position within the interval, field 2 = `mem_acc`, field 3 = `cpu_state`, field 4 = that cycle's toggles, and all other fields 0.
- R11: During and after reset, `rd_valid` and `stall_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_mode | input | 1 | 1 selects per-access event records, 0 selects interval summaries |
| cpu_state | input | 2 | Processor state code (01 active, 10 stalled, 00 idle) |
| mem_acc | input | 4 | Access strobes: icache, dcache, private, shared |
| bus_data | input | BUS_W | Monitored interconnect data |
| rd_en | input | 1 | Dispatcher read request |
| rd_valid | output | 1 | Buffer holds a record |
| rd_data | output | 9*CNT_W | Oldest buffered record |
| stall_req | output | 1 | Record pending on a full buffer; monitored source should stop |

## Verification
Two events can land on the same clock edge: the dispatcher removing a record, and an interval end that produces a new record while the buffer is full. The bench provokes this by leaving two records unread in a two-entry buffer and raising `rd_en` exactly on the last counted cycle of the next interval. It then checks that `stall_req` stays low and that all three records come out intact and in order. The non-overlapping case is also exercised: the interval end arrives with no read, the stall is observed, stimulus applied during the stall is shown to be absent from later records, and a later read releases the held record.

// File: rtl/activity_sniffer.sv
module activity_sniffer #(
  parameter int BUS_W    = 32,
  parameter int CNT_W    = 32,
  parameter int INTERVAL = 1_000_000,
  parameter int DEPTH    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_mode,
  input  logic [1:0]           cpu_state,
  input  logic [3:0]           mem_acc,
  input  logic [BUS_W-1:0]     bus_data,
  input  logic                 rd_en,
  output logic                 rd_valid,
  output logic [9*CNT_W-1:0]   rd_data,
  output logic                 stall_req
);

  localparam int NACC  = 8;
  localparam int REC_W = 9 * CNT_W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int IW    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int TW    = $clog2(BUS_W + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [IW-1:0]    ivl_q;
  logic [BUS_W-1:0] prev_q;
  logic [TW-1:0]    tog;
  logic [CNT_W-1:0] acc_q  [NACC];
  logic [CNT_W-1:0] acc_nx [NACC];
  logic [CNT_W-1:0] inc    [NACC];
  logic             pend_vld;
  logic [REC_W-1:0] pend_q;
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [FW-1:0]    fill;
  logic [REC_W-1:0] sum_rec, evt_rec, new_rec, push_rec;
  logic             run, ivl_end, gen, pop, space, push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign run     = !pend_vld;
  assign ivl_end = run && (ivl_q == IW'(INTERVAL - 1));

  always_comb begin
    tog = '0;
    for (int b = 0; b < BUS_W; b++) tog = tog + TW'(bus_data[b] ^ prev_q[b]);
  end

  always_comb begin
    inc[0] = CNT_W'(cpu_state == 2'b01);
    inc[1] = CNT_W'(cpu_state == 2'b10);
    inc[2] = CNT_W'(cpu_state == 2'b00);
    for (int m = 0; m < 4; m++) inc[3+m] = CNT_W'(mem_acc[m]);
    inc[7] = CNT_W'(tog);
    for (int j = 0; j < NACC; j++) begin
      logic [CNT_W:0] s;
      s = {1'b0, acc_q[j]} + {1'b0, inc[j]};
      acc_nx[j] = s[CNT_W] ? CMAX : s[CNT_W-1:0];
    end
  end

  always_comb begin
    sum_rec = '0;
    for (int j = 0; j < NACC; j++) sum_rec[(j+1)*CNT_W +: CNT_W] = acc_nx[j];
    evt_rec = '0;
    evt_rec[0] = 1'b1;
    evt_rec[1*CNT_W +: CNT_W] = CNT_W'(ivl_q);
    evt_rec[2*CNT_W +: CNT_W] = CNT_W'(mem_acc);
    evt_rec[3*CNT_W +: CNT_W] = CNT_W'(cpu_state);
    evt_rec[4*CNT_W +: CNT_W] = CNT_W'(tog);
  end

  assign gen      = run && (evt_mode ? (|mem_acc) : ivl_end);
  assign new_rec  = evt_mode ? evt_rec : sum_rec;
  assign rd_valid = (fill != '0);
  assign rd_data  = mem[rp];
  assign pop      = rd_en && rd_valid;
  assign space    = (fill != FW'(DEPTH)) || pop;
  assign push     = space && (pend_vld || gen);
  assign push_rec = pend_vld ? pend_q : new_rec;
  assign stall_req = pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q    <= '0;
      prev_q   <= '0;
      pend_vld <= 1'b0;
      pend_q   <= '0;
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
      for (int j = 0; j < NACC; j++) acc_q[j] <= '0;
    end else begin
      if (run) begin
        prev_q <= bus_data;
        ivl_q  <= ivl_end ? '0 : ivl_q + IW'(1);
        for (int j = 0; j < NACC; j++)
          if (ivl_end)        acc_q[j] <= '0;
          else if (!evt_mode) acc_q[j] <= acc_nx[j];
      end
      if (pend_vld && space) pend_vld <= 1'b0;
      else if (gen && !space) begin
        pend_vld <= 1'b1;
        pend_q   <= new_rec;
      end
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      fill <= fill + FW'(push) - FW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_rec;
  end

  a_r8_interval_frozen: assert property (@(posedge clk) disable iff (rst)
    stall_req |=> $stable(ivl_q));

  a_r8_stall_only_when_full: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_req) |-> (fill == FW'(DEPTH)));

  a_r7_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));

  a_r4_position_range: assert property (@(posedge clk) disable iff (rst)
    ivl_q <= IW'(INTERVAL - 1));

  a_r5_saturated_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(acc_q[7]) == CMAX && $past(run) && !$past(ivl_end)) |-> (acc_q[7] == CMAX));

  a_r9_no_stall_on_pop: assert property (@(posedge clk) disable iff (rst)
    (fill == FW'(DEPTH) && pop && gen && !pend_vld) |=> !stall_req);

endmodule

// File: tb/test_activity_sniffer.sv
module test_activity_sniffer;
  localparam int CLK_PERIOD = 10;
  localparam int BW   = 8;
  localparam int CW   = 8;
  localparam int IVL  = 40;
  localparam int DEP  = 2;
  localparam int RW   = 9 * CW;
  localparam int MAXV = 255;

  localparam int T_STA  [4] = '{1, 0, 3, 1};
  localparam int T_STB  [4] = '{2, 1, 2, 1};
  localparam int T_ACC  [4] = '{1, 6, 8, 15};
  localparam int T_MODE [4] = '{0, 1, 2, 3};
  localparam int T_ACT  [4] = '{20, 20, 0, 40};
  localparam int T_STL  [4] = '{20, 0, 20, 0};
  localparam int T_IDL  [4] = '{0, 20, 0, 0};

  logic clk = 1'b0, rst, evt_mode, rd_en;
  logic [1:0] cpu_state;
  logic [3:0] mem_acc;
  logic [BW-1:0] bus_data;
  logic rd_valid, stall_req;
  logic [RW-1:0] rd_data;

  activity_sniffer #(.BUS_W(BW), .CNT_W(CW), .INTERVAL(IVL), .DEPTH(DEP)) i_activity_sniffer (
    .clk(clk), .rst(rst), .evt_mode(evt_mode), .cpu_state(cpu_state), .mem_acc(mem_acc),
    .bus_data(bus_data), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .stall_req(stall_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [RW-1:0] exp_q[$];
  int m_acc[8];
  logic [BW-1:0] m_prev;
  int m_ivl;
  bit m_end;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int fld(input logic [RW-1:0] r, input int k);
    return int'(r[k*CW +: CW]);
  endfunction

  function automatic void sat_add(input int i, input int v);
    m_acc[i] = (m_acc[i] + v > MAXV) ? MAXV : m_acc[i] + v;
  endfunction

  task automatic drive_cycle(input logic [1:0] st, input logic [3:0] acc,
                             input logic [BW-1:0] bv, input bit rd, input string tag);
    logic [RW-1:0] r;
    int tg;
    if (rd) begin
      chk(rd_valid === 1'b1, tag, "rd_valid at read", RW'(rd_valid), RW'(1));
      if (exp_q.size() > 0) begin
        chk(rd_data === exp_q[0], tag, "record content", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end else chk(1'b0, tag, "unexpected record", rd_data, '0);
    end
    cpu_state = st; mem_acc = acc; bus_data = bv; rd_en = rd;
    m_end = 1'b0;
    if (!stall_req) begin
      tg = $countones(bv ^ m_prev);
      m_prev = bv;
      if (!evt_mode) begin
        if (st == 2'b01) sat_add(0, 1);
        if (st == 2'b10) sat_add(1, 1);
        if (st == 2'b00) sat_add(2, 1);
        for (int m = 0; m < 4; m++) if (acc[m]) sat_add(3 + m, 1);
        sat_add(7, tg);
      end else if (acc != 4'b0) begin
        r = '0;
        r[0] = 1'b1;
        r[1*CW +: CW] = CW'(m_ivl);
        r[2*CW +: CW] = CW'(acc);
        r[3*CW +: CW] = CW'(st);
        r[4*CW +: CW] = CW'(tg);
        exp_q.push_back(r);
      end
      if (m_ivl == IVL - 1) begin
        m_end = 1'b1;
        if (!evt_mode) begin
          r = '0;
          for (int j = 0; j < 8; j++) r[(j+1)*CW +: CW] = CW'(m_acc[j]);
          exp_q.push_back(r);
        end
        for (int j = 0; j < 8; j++) m_acc[j] = 0;
        m_ivl = 0;
      end else m_ivl++;
    end
    @(negedge clk);
  endtask

  task automatic run_interval(input logic [1:0] sa, input logic [1:0] sb, input logic [3:0] acc,
                              input int mode, input int nrd, input bit rd_last, input string tag);
    int i = 0;
    logic [BW-1:0] bv;
    bit rd;
    do begin
      case (mode)
        0: bv = 8'h3C;
        1: bv = i[0] ? 8'hFF : 8'h00;
        2: bv = BW'(i);
        default: bv = BW'(i ^ (i >> 1));
      endcase
      rd = (i < nrd) || (rd_last && m_ivl == IVL - 1 && !stall_req);
      drive_cycle((i < IVL/2) ? sa : sb, acc, bv, rd, tag);
      i++;
    end while (!m_end);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; evt_mode = 1'b0; rd_en = 1'b0; cpu_state = '0; mem_acc = '0; bus_data = '0;
    m_prev = '0; m_ivl = 0;
    for (int j = 0; j < 8; j++) m_acc[j] = 0;
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0, "R11", "rd_valid in reset", RW'(rd_valid), '0);
    chk(stall_req === 1'b0, "R11", "stall_req in reset", RW'(stall_req), '0);
    rst = 1'b0;

    for (int k = 0; k < 4; k++) begin
      run_interval(T_STA[k][1:0], T_STB[k][1:0], T_ACC[k][3:0], T_MODE[k], (k == 0) ? 0 : 1, 1'b0, "R7");
      chk(rd_valid === 1'b1, "R4", "record at interval end", RW'(rd_valid), RW'(1));
      chk(fld(rd_data, 0) == 0, "R6", "summary kind field", RW'(fld(rd_data, 0)), '0);
      chk(fld(rd_data, 1) == T_ACT[k], "R1", "active cycles", RW'(fld(rd_data, 1)), RW'(T_ACT[k]));
      chk(fld(rd_data, 2) == T_STL[k], "R1", "stalled cycles", RW'(fld(rd_data, 2)), RW'(T_STL[k]));
      chk(fld(rd_data, 3) == T_IDL[k], "R1", "idle cycles", RW'(fld(rd_data, 3)), RW'(T_IDL[k]));
      for (int m = 0; m < 4; m++)
        chk(fld(rd_data, 4 + m) == (T_ACC[k][m] ? IVL : 0), "R2", "access count",
            RW'(fld(rd_data, 4 + m)), RW'(T_ACC[k][m] ? IVL : 0));
      if (k == 0) chk(fld(rd_data, 8) == 4, "R3", "toggles from reset value", RW'(fld(rd_data, 8)), RW'(4));
      if (k == 1) chk(fld(rd_data, 8) == MAXV, "R5", "toggle count saturated", RW'(fld(rd_data, 8)), RW'(MAXV));
    end

    run_interval(2'b00, 2'b00, 4'b0000, 0, 1, 1'b0, "R7");
    run_interval(2'b00, 2'b00, 4'b0000, 0, 0, 1'b0, "R7");
    run_interval(2'b00, 2'b00, 4'b0000, 0, 0, 1'b0, "R8");
    chk(stall_req === 1'b1, "R8", "stall on full buffer", RW'(stall_req), RW'(1));
    for (int s = 0; s < 4; s++) drive_cycle(2'b01, 4'b1111, s[0] ? 8'hFF : 8'h00, 1'b0, "R8");
    chk(stall_req === 1'b1, "R8", "stall held without read", RW'(stall_req), RW'(1));
    drive_cycle(2'b01, 4'b1111, 8'h00, 1'b1, "R8");
    chk(stall_req === 1'b0, "R8", "stall released after read", RW'(stall_req), '0);
    run_interval(2'b10, 2'b00, 4'b0001, 0, 2, 1'b0, "R8");

    run_interval(2'b01, 2'b10, 4'b0100, 2, 0, 1'b0, "R9");
    run_interval(2'b00, 2'b01, 4'b0010, 3, 0, 1'b1, "R9");
    chk(stall_req === 1'b0, "R9", "no stall on same-cycle read and record", RW'(stall_req), '0);
    run_interval(2'b01, 2'b01, 4'b0010, 2, 2, 1'b0, "R9");

    evt_mode = 1'b1;
    drive_cycle(2'b01, 4'b0010, 8'h5A, 1'b1, "R10");
    chk(rd_data[0] === 1'b1, "R10", "event kind field", RW'(rd_data[0]), RW'(1));
    chk(fld(rd_data, 2) == 2, "R10", "event access field", RW'(fld(rd_data, 2)), RW'(2));
    drive_cycle(2'b10, 4'b0101, 8'hA5, 1'b1, "R10");
    drive_cycle(2'b00, 4'b0000, 8'hA5, 1'b1, "R10");
    run_interval(2'b00, 2'b00, 4'b0000, 0, 0, 1'b0, "R10");
    chk(rd_valid === 1'b0, "R10", "no summary in event mode", RW'(rd_valid), '0);
    evt_mode = 1'b0;
    run_interval(2'b01, 2'b10, 4'b1001, 3, 0, 1'b0, "R4");
    drive_cycle(2'b00, 4'b0000, 8'h00, 1'b1, "R4");
    drive_cycle(2'b00, 4'b0000, 8'h00, 1'b0, "R7");
    chk(rd_valid === 1'b0, "R7", "buffer drained", RW'(rd_valid), '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule